// File: doc/BRIEF.md
# Demand-Driven Two-Road Junction Light Controller

This block runs the lamps at a crossing of a main road and a side road, and gives each road a two-digit countdown in packed BCD. The main road shows green and the side road red whenever nothing calls for a change. Vehicle sensors on the two roads decide when that changes. With traffic on both roads the roads take turns: a fixed main green, a fixed side green, and a fixed yellow interval between every green and the following red. A lone side-road vehicle ends the main green at once. A side green ends at once when its sensor clears.

All timing is counted in one-second steps given by a clock-enable input `sec_tick`. Nothing in the controller moves on a clock edge where that input is low. The reset input is asynchronous and active low. Its release is synchronised inside the block, so the phase logic leaves reset two clock edges after `rst_n` rises. The countdowns are produced straight in packed BCD, with tens in bits 7:4 and units in bits 3:0, ready for an external display driver.

Top module: `junction_light_ctrl`

## Requirements
- R1: While reset is active, the main road shows green, the side road shows red, and both countdowns read 8'h00 when no vehicle is sensed.
- R2: With no vehicle on the side road, the main road stays green and the side road stays red for any number of ticks.
- R3: While both roads have vehicles, the main green lasts MAIN_GO_S ticks, counted from the first tick on which both are present. The next tick turns the main road yellow. A tick on which the two roads are not both occupied restarts that count.
- R4: Each yellow interval lasts AMBER_S ticks, and the other road shows red for all of it. A main yellow is followed by a side green. A side yellow is followed by a main green.
- R5: While both roads have vehicles, the side green lasts SIDE_GO_S ticks, then the side road turns yellow. With a vehicle on the side road only, the side green holds.
- R6: During the main green, a tick that sees a side vehicle and no main vehicle turns the main road yellow immediately.
- R7: During the side green, a tick that sees no side vehicle turns the side road yellow immediately.
- R8: On a clock edge where `sec_tick` is low, the lamps and the internal phase timing do not change.
- R9: During a timed main green, the main countdown reads MAIN_GO_S minus elapsed ticks, and the side countdown reads that value plus AMBER_S. With the defaults these start at 45 and 50.
- R10: During a timed side green, the side countdown reads SIDE_GO_S minus elapsed ticks, and the main countdown reads that value plus AMBER_S. With the defaults these start at 25 and 30.
- R11: During either yellow interval, both countdowns show the same value, running AMBER_S down to 1.
- R12: When a green phase is not being timed (the two roads are not both occupied), both countdowns read 8'h00.
- R13: In every cycle each road has exactly one lamp lit, and at least one road shows red.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-second clock enable |
| main_car | input | 1 | A vehicle is present on the main road |
| side_car | input | 1 | A vehicle is present on the side road |
| main_red | output | 1 | Main road red lamp |
| main_amber | output | 1 | Main road yellow lamp |
| main_green | output | 1 | Main road green lamp |
| side_red | output | 1 | Side road red lamp |
| side_amber | output | 1 | Side road yellow lamp |
| side_green | output | 1 | Side road green lamp |
| main_count | output | 8 | Main road countdown, packed BCD |
| side_count | output | 8 | Side road countdown, packed BCD |

## Verification
The bench builds the block with its default timing: 45 ticks of main green, 25 of side green and 5 of yellow. With these values the side countdown reaches 50 and the main countdown reaches 30, so the packed-BCD tens digit covers 0 to 5 and every decade boundary is crossed. A full alternation fits in about eighty ticks, which leaves room to run complete cycles together with the demand-driven early exits, the restart of a main count when demand breaks, and stretches without ticks inside timed phases.

// File: rtl/jl_pkg.sv
package jl_pkg;

  typedef enum logic [1:0] {
    PH_MAIN_GO  = 2'd0,
    PH_MAIN_AMB = 2'd1,
    PH_SIDE_GO  = 2'd2,
    PH_SIDE_AMB = 2'd3
  } phase_e;

  typedef struct packed {
    logic red;
    logic amber;
    logic green;
  } lamp_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/jl_phase_fsm.sv
module jl_phase_fsm
  import jl_pkg::*;
#(
  parameter int unsigned MAIN_GO_S = 45,
  parameter int unsigned SIDE_GO_S = 25,
  parameter int unsigned AMBER_S   = 5,
  parameter int unsigned CW        = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          main_car,
  input  logic          side_car,
  output phase_e        phase,
  output logic [CW-1:0] elapsed
);

  localparam logic [CW-1:0] MAIN_LAST = CW'(MAIN_GO_S - 1);
  localparam logic [CW-1:0] SIDE_LAST = CW'(SIDE_GO_S - 1);
  localparam logic [CW-1:0] AMB_LAST  = CW'(AMBER_S - 1);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          both;

  assign both = main_car & side_car;

  // next-state logic; evaluated only on tick cycles
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (tick) begin
      unique case (phase_q)
        PH_MAIN_GO: begin
          if (both) begin
            if (cnt_q == MAIN_LAST) begin
              phase_d = PH_MAIN_AMB;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end else if (side_car) begin
            phase_d = PH_MAIN_AMB;
            cnt_d   = '0;
          end else begin
            cnt_d = '0;
          end
        end
        PH_MAIN_AMB: begin
          if (cnt_q == AMB_LAST) begin
            phase_d = PH_SIDE_GO;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        PH_SIDE_GO: begin
          if (both) begin
            if (cnt_q == SIDE_LAST) begin
              phase_d = PH_SIDE_AMB;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end else if (!side_car) begin
            phase_d = PH_SIDE_AMB;
            cnt_d   = '0;
          end else begin
            cnt_d = '0;
          end
        end
        PH_SIDE_AMB: begin
          if (cnt_q == AMB_LAST) begin
            phase_d = PH_MAIN_GO;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        default: begin
          phase_d = PH_MAIN_GO;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_MAIN_GO;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase   = phase_q;
  assign elapsed = cnt_q;

endmodule

// File: rtl/jl_countdown.sv
module jl_countdown
  import jl_pkg::*;
#(
  parameter int unsigned MAIN_GO_S = 45,
  parameter int unsigned SIDE_GO_S = 25,
  parameter int unsigned AMBER_S   = 5,
  parameter int unsigned CW        = 6,
  parameter int unsigned VW        = 6
) (
  input  phase_e        phase,
  input  logic [CW-1:0] elapsed,
  input  logic          main_car,
  input  logic          side_car,
  output logic [VW-1:0] main_left,
  output logic [VW-1:0] side_left
);

  localparam logic [VW-1:0] MAIN_V = VW'(MAIN_GO_S);
  localparam logic [VW-1:0] SIDE_V = VW'(SIDE_GO_S);
  localparam logic [VW-1:0] AMB_V  = VW'(AMBER_S);

  logic [VW-1:0] el_w;
  logic          both;

  assign el_w = VW'(elapsed);
  assign both = main_car & side_car;

  always_comb begin
    main_left = '0;
    side_left = '0;
    unique case (phase)
      PH_MAIN_GO: begin
        if (both) begin
          main_left = MAIN_V - el_w;
          side_left = MAIN_V - el_w + AMB_V;
        end
      end
      PH_SIDE_GO: begin
        if (both) begin
          side_left = SIDE_V - el_w;
          main_left = SIDE_V - el_w + AMB_V;
        end
      end
      PH_MAIN_AMB, PH_SIDE_AMB: begin
        main_left = AMB_V - el_w;
        side_left = AMB_V - el_w;
      end
      default: begin
        main_left = '0;
        side_left = '0;
      end
    endcase
  end

endmodule

// File: rtl/jl_bcd_pair.sv
module jl_bcd_pair #(
  parameter int unsigned VW = 6
) (
  input  logic [VW-1:0] bin,
  output logic [7:0]    bcd
);

  localparam logic [VW-1:0] TEN = VW'(10);

  // two decimal digits; callers keep bin below 100
  assign bcd = {4'(bin / TEN), 4'(bin % TEN)};

endmodule

// File: rtl/jl_lamp_decode.sv
module jl_lamp_decode
  import jl_pkg::*;
(
  input  phase_e phase,
  output lamp_t  main_lamp,
  output lamp_t  side_lamp
);

  always_comb begin
    main_lamp = '{red: 1'b1, amber: 1'b0, green: 1'b0};
    side_lamp = '{red: 1'b1, amber: 1'b0, green: 1'b0};
    unique case (phase)
      PH_MAIN_GO:  main_lamp = '{red: 1'b0, amber: 1'b0, green: 1'b1};
      PH_MAIN_AMB: main_lamp = '{red: 1'b0, amber: 1'b1, green: 1'b0};
      PH_SIDE_GO:  side_lamp = '{red: 1'b0, amber: 1'b0, green: 1'b1};
      PH_SIDE_AMB: side_lamp = '{red: 1'b0, amber: 1'b1, green: 1'b0};
      default: ;
    endcase
  end

endmodule

// File: rtl/junction_light_ctrl.sv
module junction_light_ctrl
  import jl_pkg::*;
#(
  parameter int unsigned MAIN_GO_S = 45,
  parameter int unsigned SIDE_GO_S = 25,
  parameter int unsigned AMBER_S   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       main_car,
  input  logic       side_car,
  output logic       main_red,
  output logic       main_amber,
  output logic       main_green,
  output logic       side_red,
  output logic       side_amber,
  output logic       side_green,
  output logic [7:0] main_count,
  output logic [7:0] side_count
);

  localparam int unsigned LONG_GO  = max2(MAIN_GO_S, SIDE_GO_S);
  localparam int unsigned MAX_SHOW = LONG_GO + AMBER_S;
  localparam int unsigned CW       = $clog2(max2(LONG_GO, AMBER_S) + 1);
  localparam int unsigned VW       = max2($clog2(MAX_SHOW + 1), CW);
  localparam int unsigned ROADS    = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_q = rst_pipe[1];

  phase_e        phase;
  logic [CW-1:0] elapsed;
  lamp_t         main_lamp, side_lamp;
  logic [VW-1:0] left_val [ROADS];
  logic [7:0]    left_bcd [ROADS];

  jl_phase_fsm #(
    .MAIN_GO_S(MAIN_GO_S), .SIDE_GO_S(SIDE_GO_S), .AMBER_S(AMBER_S), .CW(CW)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_q),
    .tick     (sec_tick),
    .main_car (main_car),
    .side_car (side_car),
    .phase    (phase),
    .elapsed  (elapsed)
  );

  jl_countdown #(
    .MAIN_GO_S(MAIN_GO_S), .SIDE_GO_S(SIDE_GO_S), .AMBER_S(AMBER_S),
    .CW(CW), .VW(VW)
  ) u_cd (
    .phase     (phase),
    .elapsed   (elapsed),
    .main_car  (main_car),
    .side_car  (side_car),
    .main_left (left_val[0]),
    .side_left (left_val[1])
  );

  for (genvar r = 0; r < ROADS; r++) begin : g_road_bcd
    jl_bcd_pair #(.VW(VW)) u_bcd (
      .bin (left_val[r]),
      .bcd (left_bcd[r])
    );
  end

  jl_lamp_decode u_lamp (
    .phase     (phase),
    .main_lamp (main_lamp),
    .side_lamp (side_lamp)
  );

  assign main_red   = main_lamp.red;
  assign main_amber = main_lamp.amber;
  assign main_green = main_lamp.green;
  assign side_red   = side_lamp.red;
  assign side_amber = side_lamp.amber;
  assign side_green = side_lamp.green;
  assign main_count = left_bcd[0];
  assign side_count = left_bcd[1];

endmodule

// File: rtl/jl_checker.sv
module jl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic       main_car,
  input logic       side_car,
  input logic       main_red,
  input logic       main_amber,
  input logic       main_green,
  input logic       side_red,
  input logic       side_amber,
  input logic       side_green,
  input logic [7:0] main_count,
  input logic [7:0] side_count
);

  assert_main_one_lamp_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({main_red, main_amber, main_green}) == 1);

  assert_side_one_lamp_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({side_red, side_amber, side_green}) == 1);

  assert_one_road_red_R13: assert property (@(posedge clk) disable iff (!rst_n)
    main_red || side_red);

  assert_no_tick_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> $stable({main_red, main_amber, main_green, side_red, side_amber, side_green}));

  assert_lone_side_yield_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (main_green && sec_tick && side_car && !main_car) |=> main_amber);

  assert_side_clear_yield_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (side_green && sec_tick && !side_car) |=> side_amber);

  assert_amber_other_red_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (main_amber |-> side_red) and (side_amber |-> main_red));

  assert_amber_same_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (main_amber || side_amber) |-> (main_count == side_count));

  assert_untimed_blank_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((main_green || side_green) && !(main_car && side_car)) |->
      (main_count == 8'h00 && side_count == 8'h00));

endmodule

bind junction_light_ctrl jl_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n_q),
  .sec_tick   (sec_tick),
  .main_car   (main_car),
  .side_car   (side_car),
  .main_red   (main_red),
  .main_amber (main_amber),
  .main_green (main_green),
  .side_red   (side_red),
  .side_amber (side_amber),
  .side_green (side_green),
  .main_count (main_count),
  .side_count (side_count)
);

// File: tb/junction_light_ctrl_tb.sv
module junction_light_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MG = 45;
  localparam int SG = 25;
  localparam int AM = 5;

  logic       clk = 1'b0;
  logic       rst_n, sec_tick, main_car, side_car;
  logic       main_red, main_amber, main_green, side_red, side_amber, side_green;
  logic [7:0] main_count, side_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  junction_light_ctrl #(.MAIN_GO_S(MG), .SIDE_GO_S(SG), .AMBER_S(AM)) u_dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .main_car(main_car), .side_car(side_car),
    .main_red(main_red), .main_amber(main_amber), .main_green(main_green),
    .side_red(side_red), .side_amber(side_amber), .side_green(side_green),
    .main_count(main_count), .side_count(side_count)
  );

  typedef struct {
    logic [5:0] lamps;
    logic [7:0] mc;
    logic [7:0] sc;
    string      ltag;
    string      ctag;
  } exp_t;

  exp_t  sbq[$];
  exp_t  cur;
  int    checks = 0;
  int    failures = 0;
  int    m_ph, m_rem;
  string m_cause;

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic check(input string tag, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected result after the edge
  task automatic step(input logic t, input logic mc, input logic sc);
    exp_t e;
    logic both;
    @(negedge clk);
    sec_tick = t; main_car = mc; side_car = sc;
    both = mc && sc;
    if (!t) m_cause = "R8";
    else begin
      case (m_ph)
        0: if (both) begin
             m_cause = "R3";
             if (m_rem == 1) begin m_ph = 1; m_rem = AM; end else m_rem--;
           end else if (sc) begin
             m_cause = "R6"; m_ph = 1; m_rem = AM;
           end else begin
             m_cause = "R2"; m_rem = MG;
           end
        1: begin
             m_cause = "R4";
             if (m_rem == 1) begin m_ph = 2; m_rem = SG; end else m_rem--;
           end
        2: if (both) begin
             m_cause = "R5";
             if (m_rem == 1) begin m_ph = 3; m_rem = AM; end else m_rem--;
           end else if (!sc) begin
             m_cause = "R7"; m_ph = 3; m_rem = AM;
           end else begin
             m_cause = "R5"; m_rem = SG;
           end
        default: begin
             m_cause = "R4";
             if (m_rem == 1) begin m_ph = 0; m_rem = MG; end else m_rem--;
           end
      endcase
    end
    // lamp order: main red, amber, green, side red, amber, green
    case (m_ph)
      0: begin e.lamps = 6'b001_100;
           if (both) begin e.mc = to_bcd(m_rem); e.sc = to_bcd(m_rem + AM); e.ctag = "R9"; end
           else begin e.mc = 8'h00; e.sc = 8'h00; e.ctag = "R12"; end
         end
      1: begin e.lamps = 6'b010_100; e.mc = to_bcd(m_rem); e.sc = to_bcd(m_rem); e.ctag = "R11"; end
      2: begin e.lamps = 6'b100_001;
           if (both) begin e.sc = to_bcd(m_rem); e.mc = to_bcd(m_rem + AM); e.ctag = "R10"; end
           else begin e.mc = 8'h00; e.sc = 8'h00; e.ctag = "R12"; end
         end
      default: begin e.lamps = 6'b100_010; e.mc = to_bcd(m_rem); e.sc = to_bcd(m_rem); e.ctag = "R11"; end
    endcase
    e.ltag = m_cause;
    sbq.push_back(e);
  endtask

  // monitor: compares each queued item just after the edge it belongs to
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        cur = sbq.pop_front();
        check(cur.ltag, "lamps",
              int'({main_red, main_amber, main_green, side_red, side_amber, side_green}),
              int'(cur.lamps));
        check(cur.ctag, "main_count", int'(main_count), int'(cur.mc));
        check(cur.ctag, "side_count", int'(side_count), int'(cur.sc));
        // R13: one lamp per road, at least one road red
        check("R13", "lamp_rule",
              int'($countones({main_red, main_amber, main_green}) == 1 &&
                   $countones({side_red, side_amber, side_green}) == 1 &&
                   (main_red || side_red)), 1);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sec_tick = 1'b0; main_car = 1'b0; side_car = 1'b0;
    m_ph = 0; m_rem = MG; m_cause = "R1";
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", "lamps",
          int'({main_red, main_amber, main_green, side_red, side_amber, side_green}), 6'b001_100);
    check("R1", "main_count", int'(main_count), 0);
    check("R1", "side_count", int'(side_count), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(0, 0, 0);
    // R2: resting main green with no side demand
    repeat (8) step(1, 0, 0);
    repeat (8) step(1, 1, 0);
    // R3 restart: demand breaks mid count
    repeat (10) step(1, 1, 1);
    repeat (3) step(1, 1, 0);
    // R3/R4/R5/R8: full alternation with tick gaps
    for (int i = 0; i < 70; i++) step((i % 9) != 4, 1, 1);
    repeat (40) step(1, 1, 1);
    // R8: no tick with side-only demand pending
    repeat (3) step(0, 0, 1);
    // R6: lone side vehicle ends main green
    repeat (9) step(1, 0, 1);
    // R10 then R7
    repeat (3) step(1, 1, 1);
    step(1, 1, 0);
    repeat (8) step(1, 0, 0);
    repeat (2) @(posedge clk);
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule